// File: doc/BRIEF.md
# TDM Channel High-Impedance Control Serializer

This block tells external output buffers, one channel at a time, whether each of sixteen TDM output streams should drive or float. It produces two serial control lines that each carry one bit per clock period of a fixed 16.384 MHz clock, whatever data rates the streams use. Lane 0 carries the even-numbered streams and lane 1 the odd-numbered streams. The eight stream pairs take turns in consecutive clock periods, so every pair gets one slot in each group of eight periods. The slots run ahead of the frame boundary so that downstream logic has the enable before the channel starts. When a stream runs below the full rate, its channels are longer, and the same enable bit is sent again in each of its slots until the channel ends.

The block also drives sixteen per-stream output enables directly. Each enable follows the enable bit of the channel that the stream is currently sending. A low bit holds the stream's output in high impedance for that whole channel. The serial lanes keep shifting in every mode.

The enable bits are kept in a store of sixteen rows with 256 channels each. A simple one-bit write port loads the store. A frame pulse restarts the 2048-period frame counter.

Top module: `hzc_hiz_serializer`

## Requirements
- R1: While reset is held, `ctl_ser` and `stream_oe` are all zero and the frame count is 0.
- R2: The frame count advances by one on every clock and wraps from 2047 to 0. If `frame_pulse` is high in a cycle, the count is 0 in the next cycle.
- R3: At count c, let k = (c + 10) mod 2048. The pair index is p = k mod 8 and the slot is n = k div 8. Lane 0 carries stream 2p and lane 1 carries stream 2p+1. As a result, stream 0 channel 0 appears on lane 0 at count 2038, and streams 14 and 15 channel 0 appear at count 2045.
- R4: Each stream's 2-bit rate code sits at `rate_cfg[2s+1:2s]`. The codes are 00 = 16.384, 01 = 8.192, 10 = 4.096 and 11 = 2.048 Mb/s. The channel carried in slot n is n >> code, so a bit is sent 1, 2, 4 or 8 times. For example, a 2.048 Mb/s stream 4 sends its channel 0 bit at counts 2040, 0, 8, …, 48.
- R5: Both serial lanes present a new bit on every clock, with no idle periods.
- R6: At count c, `stream_oe[s]` equals the enable bit of stream s for channel (c div 8) >> code. A 0 means the stream output is high impedance.
- R7: A write stores `wr_bit` at row `wr_stream` and channel `wr_chan`. The new value shows on the outputs from the second clock edge after the write cycle. Without a write, the store does not change.
- R8: The outputs are registered. In the cycle where the count is c, they show the values for c.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 16.384 MHz output clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_pulse | input | 1 | Restarts the frame count at 0 on the next cycle |
| rate_cfg | input | 32 | Per-stream 2-bit rate codes |
| wr_en | input | 1 | Write strobe for the enable store |
| wr_stream | input | 4 | Stream row to write |
| wr_chan | input | 8 | Channel to write |
| wr_bit | input | 1 | Enable value to store |
| ctl_ser | output | 2 | Serial control lanes (bit 0 even streams, bit 1 odd streams) |
| stream_oe | output | 16 | Per-stream output enable for the current channel |

## Verification
The bench keeps its own frame count, stepping it on every rising edge from the frame pulse it drives. It samples on the falling edge: the count the design has just registered and the outputs for that count are both settled there, one edge after the count's predecessor. A rate change is applied on a falling edge and already holds for the next sample. After a write, the bench lets two rising edges pass before checking, because the store and then the output register each add one edge. Every count in more than two mixed-rate frames is compared against the slot arithmetic, as is a restart in the middle of a frame and frames where all streams run at the same rate.

// File: rtl/hzc_pkg.sv
package hzc_pkg;
    typedef enum logic [1:0] {
        RATE_16M = 2'b00,
        RATE_8M  = 2'b01,
        RATE_4M  = 2'b10,
        RATE_2M  = 2'b11
    } rate_code_e;
endpackage

// File: rtl/hzc_frame_ctr.sv
module hzc_frame_ctr #(
    parameter int FRAME_LEN = 2048
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         frame_pulse,
    output logic [$clog2(FRAME_LEN)-1:0] cnt_q,
    output logic [$clog2(FRAME_LEN)-1:0] cnt_d
);
    localparam int CW = $clog2(FRAME_LEN);
    localparam logic [CW-1:0] LAST = CW'(FRAME_LEN - 1);

    always_comb begin
        if (frame_pulse)        cnt_d = '0;
        else if (cnt_q == LAST) cnt_d = '0;
        else                    cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assert_frame_restart_R2: assert property (@(posedge clk) disable iff (!rst_n)
        frame_pulse |=> cnt_q == '0);
    assert_count_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!frame_pulse && cnt_q != LAST) |=> cnt_q == $past(cnt_q) + 1'b1);
    assert_frame_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!frame_pulse && cnt_q == LAST) |=> cnt_q == '0);
endmodule

// File: rtl/hzc_enable_store.sv
module hzc_enable_store #(
    parameter int STREAMS = 16,
    parameter int CHANS   = 256
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic [$clog2(STREAMS)-1:0]  wr_stream,
    input  logic [$clog2(CHANS)-1:0]    wr_chan,
    input  logic                        wr_bit,
    output logic [STREAMS-1:0][CHANS-1:0] rows_q
);
    logic [STREAMS-1:0][CHANS-1:0] rows_d;

    always_comb begin
        rows_d = rows_q;
        if (wr_en) rows_d[wr_stream][wr_chan] = wr_bit;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rows_q <= '0;
        else        rows_q <= rows_d;
    end

    assert_write_lands_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> rows_q[$past(wr_stream)][$past(wr_chan)] == $past(wr_bit));
    assert_hold_no_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(rows_q));
endmodule

// File: rtl/hzc_hiz_serializer.sv
module hzc_hiz_serializer #(
    parameter int STREAMS   = 16,
    parameter int FRAME_LEN = 2048,
    parameter int LEAD      = 10
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         frame_pulse,
    input  logic [2*STREAMS-1:0]         rate_cfg,
    input  logic                         wr_en,
    input  logic [$clog2(STREAMS)-1:0]   wr_stream,
    input  logic [$clog2(FRAME_LEN/(STREAMS/2))-1:0] wr_chan,
    input  logic                         wr_bit,
    output logic [1:0]                   ctl_ser,
    output logic [STREAMS-1:0]           stream_oe
);
    import hzc_pkg::*;

    localparam int PAIRS = STREAMS / 2;
    localparam int PB    = $clog2(PAIRS);
    localparam int CW    = $clog2(FRAME_LEN);
    localparam int CHANS = FRAME_LEN / PAIRS;
    localparam int CHW   = CW - PB;
    localparam int SW    = $clog2(STREAMS);

    typedef struct packed {
        logic [1:0]         ser;
        logic [STREAMS-1:0] oe;
    } out_t;

    logic [CW-1:0]                 cnt_q, cnt_d;
    logic [STREAMS-1:0][CHANS-1:0] rows;
    logic [CW-1:0]                 pos;
    logic [1:0]                    ser_nx;
    logic [STREAMS-1:0]            oe_nx;
    out_t                          out_d, out_q;

    hzc_frame_ctr #(.FRAME_LEN(FRAME_LEN)) u_ctr (
        .clk(clk), .rst_n(rst_n), .frame_pulse(frame_pulse),
        .cnt_q(cnt_q), .cnt_d(cnt_d)
    );

    hzc_enable_store #(.STREAMS(STREAMS), .CHANS(CHANS)) u_store (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_stream(wr_stream),
        .wr_chan(wr_chan), .wr_bit(wr_bit), .rows_q(rows)
    );

    // Slot position for the count that becomes current at the next edge
    assign pos = cnt_d + CW'(LEAD);

    for (genvar b = 0; b < 2; b++) begin : g_lane
        logic [SW-1:0]  sidx;
        rate_code_e     code;
        logic [CHW-1:0] ch;
        assign sidx       = {pos[PB-1:0], (b == 1) ? 1'b1 : 1'b0};
        assign code       = rate_code_e'(rate_cfg[2*sidx +: 2]);
        assign ch         = pos[CW-1:PB] >> code;
        assign ser_nx[b]  = rows[sidx][ch];
    end

    for (genvar s = 0; s < STREAMS; s++) begin : g_oe
        logic [CHW-1:0] ch;
        assign ch       = cnt_d[CW-1:PB] >> rate_cfg[2*s +: 2];
        assign oe_nx[s] = rows[s][ch];
    end

    always_comb begin
        out_d     = out_q;
        out_d.ser = ser_nx;
        out_d.oe  = oe_nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign ctl_ser   = out_q.ser;
    assign stream_oe = out_q.oe;

    assert_oe_follows_store_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rate_cfg[1:0] == 2'b00 && !wr_en) |=>
            stream_oe[0] == rows[0][cnt_q[CW-1:PB]]);
endmodule

// File: tb/sim_hzc_hiz_serializer.sv
module sim_hzc_hiz_serializer;
    logic        clk = 0;
    logic        rst_n = 0;
    logic        fp = 0;
    logic [31:0] rate_cfg = '0;
    logic        wr_en = 0;
    logic [3:0]  wr_stream = '0;
    logic [7:0]  wr_chan = '0;
    logic        wr_bit = 0;
    logic [1:0]  ctl_ser;
    logic [15:0] stream_oe;

    int nchk = 0, nerr = 0, cyc = 0, bcnt = 0;
    bit m [16][256];
    int rc [16];

    hzc_hiz_serializer u0 (
        .clk(clk), .rst_n(rst_n), .frame_pulse(fp), .rate_cfg(rate_cfg),
        .wr_en(wr_en), .wr_stream(wr_stream), .wr_chan(wr_chan), .wr_bit(wr_bit),
        .ctl_ser(ctl_ser), .stream_oe(stream_oe)
    );

    always #10 clk = ~clk;

    always @(posedge clk) begin
        if (!rst_n) bcnt <= 0;
        else        bcnt <= fp ? 0 : (bcnt == 2047 ? 0 : bcnt + 1);
    end

    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 150000) begin
                nerr++;
                $display("FAIL watchdog expired");
                $display("Result: errors=%0d of %0d checks", nerr, nchk);
                $finish;
            end
        end
    end

    task automatic chk(string tag, string what, logic [31:0] got, logic [31:0] exp);
        nchk++;
        if (got !== exp) begin
            nerr++;
            $display("FAIL %s %s cnt=%0d got=%0h exp=%0h", tag, what, bcnt, got, exp);
        end
    endtask

    function automatic logic exp_ser(int c, int b);
        int k = (c + 10) % 2048;
        int s = 2 * (k % 8) + b;
        return m[s][(k / 8) >> rc[s]];
    endfunction

    function automatic logic [15:0] exp_oe(int c);
        logic [15:0] e;
        for (int s = 0; s < 16; s++) e[s] = m[s][(c / 8) >> rc[s]];
        return e;
    endfunction

    task automatic apply_rates();
        for (int s = 0; s < 16; s++) rate_cfg[2*s +: 2] = rc[s][1:0];
    endtask

    task automatic run(int n, string over, int restart_at);
        bit prev_fp = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            for (int b = 0; b < 2; b++) begin
                int s = 2 * (((bcnt + 10) % 2048) % 8) + b;
                string tag = over != "" ? over : (prev_fp ? "R2" : (rc[s] == 0 ? "R3" : "R4"));
                chk(tag, b == 0 ? "ser0" : "ser1", 32'(ctl_ser[b]), 32'(exp_ser(bcnt, b)));
            end
            chk(over != "" ? over : (prev_fp ? "R2" : "R6"), "oe", 32'(stream_oe), 32'(exp_oe(bcnt)));
            if (bcnt == 2038) chk("R3", "s0ch0", 32'(ctl_ser[0]), 32'(m[0][0 >> rc[0]]));
            if (bcnt == 2045) chk("R3", "s14s15ch0", 32'(ctl_ser), 32'({m[15][0], m[14][0]}));
            if (bcnt == 2040 && rc[4] == 3) chk("R4", "s4ch0rep", 32'(ctl_ser[0]), 32'(m[4][0]));
            prev_fp = fp;
            fp = (bcnt == restart_at);
        end
        @(negedge clk);
        fp = 0;
    endtask

    initial begin
        // R1: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1", "ser_reset", 32'(ctl_ser), 32'h0);
        chk("R1", "oe_reset", 32'(stream_oe), 32'h0);
        rst_n = 1;

        rc = '{0, 1, 2, 3, 3, 2, 1, 0, 1, 3, 0, 2, 2, 0, 3, 1};
        apply_rates();
        for (int s = 0; s < 16; s++)
            for (int c = 0; c < 256; c++) begin
                m[s][c] = ((s * 5 + c * 3 + c / 7) % 3) == 0;
                @(negedge clk);
                wr_en = 1; wr_stream = 4'(s); wr_chan = 8'(c); wr_bit = m[s][c];
            end
        @(negedge clk);
        wr_en = 0;
        @(negedge clk);

        // R3 R4 R5 R6 R8 mixed rates, restart mid-frame (R2)
        run(2 * 2048 + 100, "", 700);

        // R4: all streams at 2.048 Mb/s
        for (int s = 0; s < 16; s++) rc[s] = 3;
        apply_rates();
        run(2048, "R4", -1);

        // R3: all streams at 16.384 Mb/s
        for (int s = 0; s < 16; s++) rc[s] = 0;
        apply_rates();
        run(2048, "R3", -1);

        // R7: rewrite two rows, then check every count
        rc = '{0, 1, 2, 3, 3, 2, 1, 0, 1, 3, 0, 2, 2, 0, 3, 1};
        apply_rates();
        for (int c = 0; c < 256; c++)
            for (int s = 5; s <= 10; s += 5) begin
                m[s][c] = !m[s][c];
                @(negedge clk);
                wr_en = 1; wr_stream = 4'(s); wr_chan = 8'(c); wr_bit = m[s][c];
            end
        @(negedge clk);
        wr_en = 0;
        @(negedge clk);
        run(2048, "R7", -1);

        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule